// File: doc/BRIEF.md
# Mixed-Width Integer Add with Lane Writeback

This block adds two integer source elements whose widths may differ (8, 16, 32 or 64 bits) and forms the new contents of one 64-bit register entry. Each source is widened, according to its own signedness, to the larger of the two source widths. The sum is computed at that width. The destination width only comes into play afterwards, when the result is narrowed or widened for storage.

The destination can be a scalar or a vector. For a scalar, the result is extended to the full 64 bits and replaces the whole entry. For a vector, only one lane of the destination width is written, and every other byte keeps the value presented on the current-entry input. The caller supplies the present register contents, takes the registered entry and a one-cycle write strobe, and writes them back to its register file.

Top module: `pwb_alu_wb`

## Requirements
- R1: While `rst_n` is low, `wr_entry` reads 0 and `wr_strobe` reads 0, whatever the other inputs do.
- R2: `wr_strobe` is high in the cycle after a cycle with `op_valid` high, and low otherwise. `wr_entry` keeps its value after a cycle without `op_valid`.
- R3: Width codes are 0 = 8 bits, 1 = 16 bits, 2 = 32 bits and 3 = 64 bits, the same for `a_ew`, `b_ew` and `dst_ew`. Each source keeps its low bits for its width code and is sign-extended (when its signed flag is 1) or zero-extended to the larger source width W. The sum is taken modulo 2^W, so a carry out of W bits is lost.
- R4: With `dst_vec` = 0, the W-bit sum is extended to 64 bits and becomes the whole of `wr_entry`. The extension copies bit W-1 when `res_signed` = 1 and fills with zeros when it is 0. `cur_entry` has no effect.
- R5: With `dst_vec` = 1, only the bytes of the selected lane change. Every other byte of `wr_entry` equals the same byte of `cur_entry`.
- R6: With a vector destination narrower than W, the lane receives the low bits of the W-bit sum, so truncation happens after the add.
- R7: With a vector destination wider than W, the lane receives the W-bit sum extended by `res_signed` as in R4.
- R8: Lanes are numbered from the least significant end. Lane n of width code d covers bits starting at n·(8<<d). Only the low bits of `dst_lane` that can count the lanes of that width are used (3 for 8-bit, 2 for 16-bit, 1 for 32-bit, none for 64-bit); the higher bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation present this cycle |
| src_a | input | 64 | First source element, low-aligned |
| a_ew | input | 2 | Width code of first source |
| a_signed | input | 1 | First source is sign-extended |
| src_b | input | 64 | Second source element, low-aligned |
| b_ew | input | 2 | Width code of second source |
| b_signed | input | 1 | Second source is sign-extended |
| dst_ew | input | 2 | Width code of destination lane |
| dst_lane | input | 3 | Destination lane index |
| dst_vec | input | 1 | Destination is a vector (lane write) |
| res_signed | input | 1 | Result is sign-extended beyond W |
| cur_entry | input | 64 | Present contents of destination entry |
| wr_entry | output | 64 | Registered new entry contents |
| wr_strobe | output | 1 | One-cycle write strobe |

## Verification
Two things can happen in the same cycle: the output register presents the result of one operation while it captures the next. The bench provokes this by issuing operations on back-to-back cycles, changing the destination kind, the lane and the widths between them. Each result is judged on the cycle after its own issue against a model computed from the requirements. A vector write that narrows a wide sum and merges it into a lane is also checked in a single operation, which tests R5 and R6 together.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
   localparam int REG_BITS = 64;

   typedef enum logic [1:0] {
      EW_B8  = 2'd0,
      EW_B16 = 2'd1,
      EW_B32 = 2'd2,
      EW_B64 = 2'd3
   } ew_code_e;

   function automatic int unsigned ew_to_bits(input int unsigned code);
      return 32'd8 << code;
   endfunction
endpackage

// File: rtl/pwb_extend.sv
module pwb_extend #(
   parameter int XLEN = pwb_pkg::REG_BITS,
   localparam int NUMW = $clog2(XLEN / 8) + 1,
   localparam int EWW  = (NUMW > 1) ? $clog2(NUMW) : 1
) (
   input  logic [XLEN-1:0] val_in,
   input  logic [EWW-1:0]  ew,
   input  logic            sext,
   output logic [XLEN-1:0] val_out
);
   logic [XLEN-1:0] cand [NUMW];

   for (genvar g = 0; g < NUMW; g++) begin : g_width
      localparam int B = 8 << g;
      if (B >= XLEN) begin : g_full
         assign cand[g] = val_in;
      end else begin : g_part
         assign cand[g] = {{(XLEN-B){sext & val_in[B-1]}}, val_in[B-1:0]};
      end
   end

   always_comb begin
      val_out = cand[0];
      for (int i = 0; i < NUMW; i++) begin
         if (ew == EWW'(i)) val_out = cand[i];
      end
   end
endmodule

// File: rtl/pwb_adder.sv
module pwb_adder #(
   parameter int XLEN = pwb_pkg::REG_BITS,
   localparam int NUMW = $clog2(XLEN / 8) + 1,
   localparam int EWW  = (NUMW > 1) ? $clog2(NUMW) : 1
) (
   input  logic [XLEN-1:0] opa,
   input  logic [EWW-1:0]  opa_ew,
   input  logic            opa_sgn,
   input  logic [XLEN-1:0] opb,
   input  logic [EWW-1:0]  opb_ew,
   input  logic            opb_sgn,
   output logic [XLEN-1:0] sum_raw,
   output logic [EWW-1:0]  op_ew
);
   logic [XLEN-1:0] wide_a;
   logic [XLEN-1:0] wide_b;

   // Extending to XLEN and adding is exact at the wider source width;
   // upper bits are discarded later by the result extender.
   pwb_extend #(.XLEN(XLEN)) u_ext_a (
      .val_in(opa), .ew(opa_ew), .sext(opa_sgn), .val_out(wide_a));
   pwb_extend #(.XLEN(XLEN)) u_ext_b (
      .val_in(opb), .ew(opb_ew), .sext(opb_sgn), .val_out(wide_b));

   assign op_ew   = (opa_ew > opb_ew) ? opa_ew : opb_ew;
   assign sum_raw = wide_a + wide_b;
endmodule

// File: rtl/pwb_lane_merge.sv
module pwb_lane_merge #(
   parameter int XLEN = pwb_pkg::REG_BITS,
   localparam int NUMW   = $clog2(XLEN / 8) + 1,
   localparam int EWW    = (NUMW > 1) ? $clog2(NUMW) : 1,
   localparam int NBYTE  = XLEN / 8,
   localparam int LANE_W = (NBYTE > 1) ? $clog2(NBYTE) : 1,
   localparam int SHW    = $clog2(XLEN)
) (
   input  logic [XLEN-1:0]   old_val,
   input  logic [XLEN-1:0]   new_val,
   input  logic [EWW-1:0]    lane_ew,
   input  logic [LANE_W-1:0] lane_idx,
   input  logic              lane_mode,
   output logic [XLEN-1:0]   merged
);
   logic [LANE_W-1:0] lane_m;
   logic [SHW-1:0]    shamt;
   logic [XLEN-1:0]   placed;
   logic [NBYTE-1:0]  sel    [NUMW];
   logic [NBYTE-1:0]  bytesel;

   always_comb begin
      lane_m = lane_idx & LANE_W'((NBYTE >> lane_ew) - 1);
      shamt  = SHW'(lane_m) << (lane_ew + 3);
      placed = new_val << shamt;
   end

   for (genvar g = 0; g < NUMW; g++) begin : g_wsel
      for (genvar k = 0; k < NBYTE; k++) begin : g_byte
         localparam logic [LANE_W-1:0] OWNER = LANE_W'(k >> g);
         assign sel[g][k] = (OWNER == lane_m);
      end
   end

   always_comb begin
      bytesel = '1;
      if (lane_mode) begin
         for (int i = 0; i < NUMW; i++) begin
            if (lane_ew == EWW'(i)) bytesel = sel[i];
         end
      end
   end

   for (genvar k = 0; k < NBYTE; k++) begin : g_out
      assign merged[8*k +: 8] = !bytesel[k] ? old_val[8*k +: 8] :
                                lane_mode   ? placed[8*k +: 8]  :
                                              new_val[8*k +: 8];
   end
endmodule

// File: rtl/pwb_alu_wb.sv
module pwb_alu_wb #(
   parameter int XLEN = pwb_pkg::REG_BITS,
   localparam int NUMW   = $clog2(XLEN / 8) + 1,
   localparam int EWW    = (NUMW > 1) ? $clog2(NUMW) : 1,
   localparam int LANE_W = (XLEN / 8 > 1) ? $clog2(XLEN / 8) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [XLEN-1:0]   src_a,
   input  logic [EWW-1:0]    a_ew,
   input  logic              a_signed,
   input  logic [XLEN-1:0]   src_b,
   input  logic [EWW-1:0]    b_ew,
   input  logic              b_signed,
   input  logic [EWW-1:0]    dst_ew,
   input  logic [LANE_W-1:0] dst_lane,
   input  logic              dst_vec,
   input  logic              res_signed,
   input  logic [XLEN-1:0]   cur_entry,
   output logic [XLEN-1:0]   wr_entry,
   output logic              wr_strobe
);
   if (XLEN < 16 || (XLEN & (XLEN - 1)) != 0) begin : g_bad_xlen
      $error("pwb_alu_wb: XLEN must be a power of two of at least 16");
   end

   logic [XLEN-1:0] sum_raw;
   logic [EWW-1:0]  op_ew;
   logic [XLEN-1:0] res_full;
   logic [XLEN-1:0] next_entry;

   pwb_adder #(.XLEN(XLEN)) u_add (
      .opa(src_a), .opa_ew(a_ew), .opa_sgn(a_signed),
      .opb(src_b), .opb_ew(b_ew), .opb_sgn(b_signed),
      .sum_raw(sum_raw), .op_ew(op_ew));

   // Narrow the sum to the operation width, then widen for storage.
   pwb_extend #(.XLEN(XLEN)) u_res_ext (
      .val_in(sum_raw), .ew(op_ew), .sext(res_signed), .val_out(res_full));

   pwb_lane_merge #(.XLEN(XLEN)) u_merge (
      .old_val(cur_entry), .new_val(res_full), .lane_ew(dst_ew),
      .lane_idx(dst_lane), .lane_mode(dst_vec), .merged(next_entry));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_entry  <= '0;
         wr_strobe <= 1'b0;
      end else begin
         wr_strobe <= op_valid;
         if (op_valid) wr_entry <= next_entry;
      end
   end
endmodule

// File: rtl/pwb_alu_wb_chk.sv
module pwb_alu_wb_chk #(
   parameter int XLEN = 64,
   localparam int NUMW   = $clog2(XLEN / 8) + 1,
   localparam int EWW    = (NUMW > 1) ? $clog2(NUMW) : 1,
   localparam int LANE_W = (XLEN / 8 > 1) ? $clog2(XLEN / 8) : 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              op_valid,
   input logic [XLEN-1:0]   src_a,
   input logic [EWW-1:0]    a_ew,
   input logic [XLEN-1:0]   src_b,
   input logic [EWW-1:0]    b_ew,
   input logic [EWW-1:0]    dst_ew,
   input logic [LANE_W-1:0] dst_lane,
   input logic              dst_vec,
   input logic              res_signed,
   input logic [XLEN-1:0]   cur_entry,
   input logic [XLEN-1:0]   wr_entry,
   input logic              wr_strobe
);
   logic [7:0] low_sum;
   assign low_sum = src_a[7:0] + src_b[7:0];

   assert_strobe_on_R2: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid |=> wr_strobe);
   assert_strobe_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> !wr_strobe);
   assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> $stable(wr_entry));
   assert_scalar_zero_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && !dst_vec && !res_signed && a_ew == '0 && b_ew == '0)
      |=> wr_entry[XLEN-1:8] == '0);
   assert_scalar_sign_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && !dst_vec && res_signed && a_ew == '0 && b_ew == '0)
      |=> wr_entry[XLEN-1:8] == {(XLEN-8){wr_entry[7]}});
   assert_lane_keeps_rest_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && dst_vec && dst_ew == '0 && dst_lane == '0)
      |=> wr_entry[XLEN-1:8] == $past(cur_entry[XLEN-1:8]));
   assert_trunc_after_add_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && dst_vec && dst_ew == '0 && dst_lane == '0)
      |=> wr_entry[7:0] == $past(low_sum));
endmodule

bind pwb_alu_wb pwb_alu_wb_chk #(.XLEN(XLEN)) u_chk (
   .clk(clk), .rst_n(rst_n), .op_valid(op_valid),
   .src_a(src_a), .a_ew(a_ew), .src_b(src_b), .b_ew(b_ew),
   .dst_ew(dst_ew), .dst_lane(dst_lane), .dst_vec(dst_vec),
   .res_signed(res_signed), .cur_entry(cur_entry),
   .wr_entry(wr_entry), .wr_strobe(wr_strobe));

// File: tb/tb_pwb_alu_wb.sv
module tb_pwb_alu_wb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [63:0] src_a = '0, src_b = '0, cur_entry = '0;
   logic [1:0]  a_ew = '0, b_ew = '0, dst_ew = '0;
   logic        a_signed = 1'b0, b_signed = 1'b0, dst_vec = 1'b0, res_signed = 1'b0;
   logic [2:0]  dst_lane = '0;
   logic [63:0] wr_entry;
   logic        wr_strobe;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #5 clk = ~clk;

   pwb_alu_wb dut (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid),
      .src_a(src_a), .a_ew(a_ew), .a_signed(a_signed),
      .src_b(src_b), .b_ew(b_ew), .b_signed(b_signed),
      .dst_ew(dst_ew), .dst_lane(dst_lane), .dst_vec(dst_vec),
      .res_signed(res_signed), .cur_entry(cur_entry),
      .wr_entry(wr_entry), .wr_strobe(wr_strobe));

   function automatic logic [63:0] xt(logic [63:0] v, int n, bit s);
      logic [63:0] m;
      if (n >= 64) return v;
      m  = (64'd1 << n) - 64'd1;
      xt = v & m;
      if (s && v[n-1]) xt = xt | ~m;
   endfunction

   function automatic logic [63:0] model(logic [63:0] a, int aw, bit as,
         logic [63:0] b, int bw, bit bs, int dw, int lane, bit vec, bit rs,
         logic [63:0] old);
      int na = 8 << aw, nb = 8 << bw, nd = 8 << dw;
      int w = (na > nb) ? na : nb;
      logic [63:0] full, mask;
      int idx, sh;
      full = xt(xt(a, na, as) + xt(b, nb, bs), w, rs);
      if (!vec) return full;
      idx  = lane % (64 / nd);
      sh   = idx * nd;
      mask = ((nd == 64) ? ~64'd0 : ((64'd1 << nd) - 64'd1)) << sh;
      return (old & ~mask) | ((full << sh) & mask);
   endfunction

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic drive(logic [63:0] a, int aw, bit as, logic [63:0] b, int bw,
         bit bs, int dw, int lane, bit vec, bit rs, logic [63:0] old);
      src_a = a; a_ew = 2'(aw); a_signed = as;
      src_b = b; b_ew = 2'(bw); b_signed = bs;
      dst_ew = 2'(dw); dst_lane = 3'(lane); dst_vec = vec;
      res_signed = rs; cur_entry = old; op_valid = 1'b1;
   endtask

   task automatic one_op(string req, logic [63:0] a, int aw, bit as,
         logic [63:0] b, int bw, bit bs, int dw, int lane, bit vec, bit rs,
         logic [63:0] old);
      @(negedge clk);
      drive(a, aw, as, b, bw, bs, dw, lane, vec, rs, old);
      @(negedge clk);
      op_valid = 1'b0;
      chk({req, " strobe (R2)"}, {63'd0, wr_strobe}, 64'd1);
      chk(req, wr_entry, model(a, aw, as, b, bw, bs, dw, lane, vec, rs, old));
   endtask

   task automatic t_reset;
      drive(64'hFF, 0, 1, 64'h1, 0, 0, 3, 0, 0, 1, 64'h1234);
      repeat (3) @(negedge clk);
      chk("R1 entry in reset", wr_entry, 64'd0);
      chk("R1 strobe in reset", {63'd0, wr_strobe}, 64'd0);
      op_valid = 1'b0;
      rst_n = 1'b1;
   endtask

   task automatic t_scalar;
      one_op("R4 scalar zero-extend 8+8 carry dropped (R3)", 64'hAAAA_BBBB_CCCC_00F0,
             0, 0, 64'h5555_0000_0000_0020, 0, 0, 0, 0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF);
      one_op("R4 scalar sign-extend 8+8", 64'h70, 0, 0, 64'h10, 0, 0, 0, 0, 0, 1,
             64'hDEAD_BEEF_DEAD_BEEF);
      one_op("R3 mixed signed 8 + unsigned 32", 64'hFF, 0, 1, 64'h0000_0010, 2, 0,
             3, 0, 0, 1, 64'h0);
      one_op("R3 zero-ext 16 + sign-ext 8 -> scalar", 64'h8000, 1, 0, 64'hFE, 0, 1,
             1, 0, 0, 1, 64'h0);
      one_op("R3 64-bit add", 64'hFFFF_FFFF_FFFF_FFFF, 3, 0, 64'h2, 3, 0, 3, 0, 0, 0, 64'h0);
   endtask

   task automatic t_lanes;
      for (int d = 0; d < 4; d++) begin
         for (int l = 0; l < (8 >> d); l++) begin
            one_op($sformatf("R5 R8 lane %0d width code %0d", l, d),
                   64'h0123_4567_89AB_CDEF, d, 0, 64'h1111_1111_1111_1111 * (l + 1),
                   d, 1, d, l, 1, 1, 64'hA5A5_A5A5_A5A5_A5A5);
         end
      end
   endtask

   task automatic t_trunc_widen;
      one_op("R6 R5 32-bit sum truncated into 8-bit lane 5", 64'h0000_12FF, 2, 0,
             64'h0000_0003, 2, 0, 0, 5, 1, 0, 64'h7766_5544_3322_1100);
      one_op("R7 8-bit sum sign-widened into 32-bit lane 1", 64'h80, 0, 1, 64'h01, 0, 1,
             2, 1, 1, 1, 64'h0BAD_F00D_0BAD_F00D);
      one_op("R7 8-bit sum zero-widened into 16-bit lane 2", 64'h80, 0, 1, 64'h01, 0, 1,
             1, 2, 1, 0, 64'h0BAD_F00D_0BAD_F00D);
   endtask

   task automatic t_lane_wrap;
      one_op("R8 16-bit lane index 6 wraps to 2", 64'h1234, 1, 0, 64'h1, 1, 0, 1, 6, 1,
             0, 64'hFFFF_FFFF_FFFF_FFFF);
      one_op("R8 64-bit lane index 7 ignored", 64'h5, 3, 0, 64'h6, 3, 0, 3, 7, 1, 0,
             64'hFFFF_FFFF_FFFF_FFFF);
   endtask

   task automatic t_back_to_back;
      logic [63:0] e1, e2;
      e1 = model(64'hF0, 0, 1, 64'h0F00, 1, 0, 0, 3, 1, 0, 64'h1122_3344_5566_7788);
      e2 = model(64'h7FFF_FFFF, 2, 1, 64'h1, 2, 0, 3, 0, 0, 1, 64'h0);
      @(negedge clk);
      drive(64'hF0, 0, 1, 64'h0F00, 1, 0, 0, 3, 1, 0, 64'h1122_3344_5566_7788);
      @(negedge clk);
      chk("R2 back-to-back first strobe", {63'd0, wr_strobe}, 64'd1);
      chk("R5 back-to-back first result", wr_entry, e1);
      drive(64'h7FFF_FFFF, 2, 1, 64'h1, 2, 0, 3, 0, 0, 1, 64'h0);
      @(negedge clk);
      op_valid = 1'b0;
      chk("R2 back-to-back second strobe", {63'd0, wr_strobe}, 64'd1);
      chk("R4 back-to-back second result", wr_entry, e2);
   endtask

   task automatic t_hold;
      logic [63:0] kept;
      kept = wr_entry;
      @(negedge clk);
      src_a = 64'h9999; cur_entry = 64'h1; dst_vec = 1'b1;
      @(negedge clk);
      chk("R2 idle strobe low", {63'd0, wr_strobe}, 64'd0);
      chk("R2 idle entry held", wr_entry, kept);
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      t_reset();
      t_scalar();
      t_lanes();
      t_trunc_widen();
      t_lane_wrap();
      t_back_to_back();
      t_hold();
      finish_run();
   end

   initial begin
      #2000000;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end
endmodule